// File: doc/BRIEF.md
# System Exception Pending and Status Registers

This block holds the pending flags of the core's seven pendable system exceptions: non-maskable interrupt, deferred service call, periodic timer tick, memory-management fault, bus fault, usage fault and supervisor call. It also holds the enables of the three configurable fault handlers, the vector-table base address and a keyed reset-request register. Software reaches all of this through a simple word-wide register bus. Peripherals and the exception sequencer raise and drop pending flags through per-exception set and clear strobes.

Reads are combinational from the byte offset. They merge the stored flags with live state from the exception logic: the active vector, the highest pending vector, whether the active handler preempted another, per-exception active flags and the pending state of the external interrupts.

The exception logic counts external interrupts from 32 and uses 1023 for "none". Software sees them counted from 16, with 0 for "none". Arbitration between exceptions happens elsewhere. This block only stores and presents state.

Top module: `sysexc_ctrl_regs`

## Requirements
- R1: A write to offset 0xD04 with bit 31 set makes the non-maskable interrupt pending (pend_o bit 0) from the next cycle.
- R2: In a write to 0xD04, bit 28 sets the deferred-call pending flag (pend_o bit 1) and bit 27 clears it. When both bits are 1 the flag is set.
- R3: In a write to 0xD04, bit 26 sets the timer-tick pending flag (pend_o bit 2) and bit 25 clears it. When both bits are 1 the flag is set.
- R4: A read of 0xD04 returns the following fields:
  - [8:0]: the active vector.
  - bit 11: set when nothing is active or the active handler did not preempt another.
  - [21:12]: the highest pending vector.
  - bit 22: the OR of all external pending inputs.
  - bit 26: the timer-tick pending flag.
  - bit 28: the deferred-call pending flag.
  - bit 31: the non-maskable interrupt pending flag.
- R5: Vector inputs are translated on read as follows:
  - 1023 reads as 0.
  - A value of 32 or more reads 16 lower.
  - A value below 32 reads unchanged.
- R6: A read of 0xD24 returns the following bits:
  - Active flags: bit 0 memory fault, bit 1 bus fault, bit 3 usage fault, bit 7 supervisor call, bit 8 debug monitor, bit 10 deferred call, bit 11 timer tick.
  - Pending flags: bit 12 usage fault, bit 13 memory fault, bit 14 bus fault, bit 15 supervisor call.
  - Fault enables in bits 18:16.
- R7: A write to 0xD24 loads the fault enables from bits 16 (memory), 17 (bus) and 18 (usage) into fault_en_o bits 0, 1 and 2.
- R8: A write to 0xD08 stores bits [31:7]. Bits [6:0] of the register always read as zero, on the bus and on vbase_o.
- R9: A read of 0xD0C returns 0x0FA05000.
- R10: A write to 0xD0C with 0x05FA in bits [31:16] and bit 0 or bit 2 set raises sys_rst_req_o for exactly the next cycle.
- R11: A write to 0xD0C without the 0x05FA key, or with neither bit 0 nor bit 2 set, requests no reset and changes no state.
- R12: Strobes from outside the bus combine with register writes as follows:
  - hw_set_i and register sets to the same flag are OR-combined in the same cycle.
  - A set beats any clear.
  - hw_clr_i drops a flag when no set is present.
  - pend_o bit order is non-maskable, deferred call, timer tick, memory, bus, usage, supervisor call.
- R13: After reset, all pending flags, fault enables, the base address and the reset request are zero.
- R14: Other offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| act_vec_i | input | 10 | Active vector, internal numbering (1023 = none) |
| act_nested_i | input | 1 | Active handler preempted another handler |
| pnd_vec_i | input | 10 | Highest pending vector, internal numbering (1023 = none) |
| ext_pend_i | input | N_EXT | Pending state of external interrupts |
| act_state_i | input | 7 | Active flags: memory, bus, usage, supervisor call, debug monitor, deferred call, timer tick (bit 0 first) |
| hw_set_i | input | 7 | Per-exception pending set strobes |
| hw_clr_i | input | 7 | Per-exception pending clear strobes |
| pend_o | output | 7 | Pending flags |
| fault_en_o | output | 3 | Memory, bus, usage fault handler enables |
| vbase_o | output | 32 | Vector-table base address |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Each write or strobe acts on the clock edge that samples it. Pending flags, enables and the base address therefore change one cycle after the write is presented. The reset request is high during that single following cycle and low in the one after. Reads carry no delay: bus_rdata follows bus_addr and the live inputs within the same cycle. The bench drives every input on the falling edge and samples registered results on the next falling edge. It samples reads one nanosecond after changing the offset, so each check lands exactly where the result is due.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    localparam int DATA_W  = 32;
    localparam int VEC_W   = 10;
    localparam int OFS_W   = 12;
    localparam int N_PEND  = 7;
    localparam int N_ACT   = 7;
    localparam int N_FEN   = 3;

    // pending flag positions
    localparam int PI_NMI = 0;
    localparam int PI_PSV = 1;
    localparam int PI_STK = 2;
    localparam int PI_MEM = 3;
    localparam int PI_BUS = 4;
    localparam int PI_USG = 5;
    localparam int PI_SVC = 6;

    // active flag positions on act_state_i
    localparam int AI_MEM = 0;
    localparam int AI_BUS = 1;
    localparam int AI_USG = 2;
    localparam int AI_SVC = 3;
    localparam int AI_DBG = 4;
    localparam int AI_PSV = 5;
    localparam int AI_STK = 6;

    // fault enable positions
    localparam int FE_MEM = 0;
    localparam int FE_BUS = 1;
    localparam int FE_USG = 2;

    // register offsets
    localparam logic [OFS_W-1:0] OFS_CTRL  = 12'hD04;
    localparam logic [OFS_W-1:0] OFS_VBASE = 12'hD08;
    localparam logic [OFS_W-1:0] OFS_RSTC  = 12'hD0C;
    localparam logic [OFS_W-1:0] OFS_HND   = 12'hD24;

    // control/state word field positions
    localparam int CB_NMI_SET = 31;
    localparam int CB_PSV_SET = 28;
    localparam int CB_PSV_CLR = 27;
    localparam int CB_STK_SET = 26;
    localparam int CB_STK_CLR = 25;
    localparam int CB_EXT_ANY = 22;
    localparam int CB_PND_LSB = 12;
    localparam int CB_BASE    = 11;
    localparam int ACT_FLD_W  = 9;

    // handler word: enables start here
    localparam int HB_EN_LSB  = 16;

    localparam logic [VEC_W-1:0] VEC_NONE    = '1;
    localparam logic [VEC_W-1:0] VEC_EXT_INT = VEC_W'(32);
    localparam logic [VEC_W-1:0] VEC_SHIFT   = VEC_W'(16);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_VBASE,
        SEL_RSTC,
        SEL_HND
    } reg_sel_t;

    typedef struct packed {
        logic [N_PEND-1:0] set;
        logic [N_PEND-1:0] clr;
    } pend_req_t;

    typedef struct packed {
        logic [VEC_W-1:0] act;
        logic [VEC_W-1:0] pnd;
        logic             nested;
        logic             ext_any;
    } vec_view_t;

    function automatic reg_sel_t decode_ofs(input logic [OFS_W-1:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_VBASE: return SEL_VBASE;
            OFS_RSTC:  return SEL_RSTC;
            OFS_HND:   return SEL_HND;
            default:   return SEL_NONE;
        endcase
    endfunction

    // internal numbering -> bus numbering
    function automatic logic [VEC_W-1:0] to_bus_vec(input logic [VEC_W-1:0] v);
        if (v == VEC_NONE)
            return '0;
        else if (v >= VEC_EXT_INT)
            return v - VEC_SHIFT;
        else
            return v;
    endfunction

    function automatic pend_req_t ctrl_write_req(input logic [DATA_W-1:0] d);
        pend_req_t r;
        r = '0;
        r.set[PI_NMI] = d[CB_NMI_SET];
        r.set[PI_PSV] = d[CB_PSV_SET];
        r.clr[PI_PSV] = d[CB_PSV_CLR];
        r.set[PI_STK] = d[CB_STK_SET];
        r.clr[PI_STK] = d[CB_STK_CLR];
        return r;
    endfunction

endpackage

// File: rtl/sysexc_pend.sv
module sysexc_pend #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/sysexc_cfg.sv
module sysexc_cfg
    import sysexc_pkg::*;
#(
    parameter int          VBASE_LSB = 7,
    parameter logic [15:0] RST_KEY   = 16'h05FA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vbase_i,
    input  logic              wr_hnd_i,
    input  logic              wr_rstc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] vbase_o,
    output logic [N_FEN-1:0]  fen_o,
    output logic              rst_req_o
);

    localparam int VB_W    = DATA_W - VBASE_LSB;
    localparam int KEY_LSB = DATA_W - 16;

    logic [VB_W-1:0] vb_q;
    logic            key_ok;
    logic            req_d;
    logic            unused_low;

    assign key_ok     = (wdata_i[DATA_W-1:KEY_LSB] == RST_KEY);
    assign req_d      = wr_rstc_i && key_ok && (wdata_i[0] || wdata_i[2]);
    assign unused_low = ^wdata_i[VBASE_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q      <= '0;
            fen_o     <= '0;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= req_d;
            if (wr_vbase_i)
                vb_q <= wdata_i[DATA_W-1:VBASE_LSB];
            if (wr_hnd_i)
                fen_o <= wdata_i[HB_EN_LSB +: N_FEN];
        end
    end

    assign vbase_o = {vb_q, {VBASE_LSB{1'b0}}};

endmodule

// File: rtl/sysexc_rdmux.sv
module sysexc_rdmux
    import sysexc_pkg::*;
#(
    parameter logic [31:0] RSTC_RDVAL = 32'h0FA0_5000
) (
    input  reg_sel_t          sel_i,
    input  vec_view_t         view_i,
    input  logic [N_PEND-1:0] pend_i,
    input  logic [N_ACT-1:0]  act_i,
    input  logic [N_FEN-1:0]  fen_i,
    input  logic [DATA_W-1:0] vbase_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [VEC_W-1:0]  act_b;
    logic [VEC_W-1:0]  pnd_b;
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] hnd_w;
    logic              unused_act_msb;

    assign act_b          = to_bus_vec(view_i.act);
    assign pnd_b          = to_bus_vec(view_i.pnd);
    assign unused_act_msb = act_b[VEC_W-1];

    always_comb begin
        ctrl_w = '0;
        ctrl_w[0 +: ACT_FLD_W]      = act_b[ACT_FLD_W-1:0];
        ctrl_w[CB_BASE]             = (view_i.act == VEC_NONE) || !view_i.nested;
        ctrl_w[CB_PND_LSB +: VEC_W] = pnd_b;
        ctrl_w[CB_EXT_ANY]          = view_i.ext_any;
        ctrl_w[CB_STK_SET]          = pend_i[PI_STK];
        ctrl_w[CB_PSV_SET]          = pend_i[PI_PSV];
        ctrl_w[CB_NMI_SET]          = pend_i[PI_NMI];
    end

    always_comb begin
        hnd_w = '0;
        hnd_w[0]  = act_i[AI_MEM];
        hnd_w[1]  = act_i[AI_BUS];
        hnd_w[3]  = act_i[AI_USG];
        hnd_w[7]  = act_i[AI_SVC];
        hnd_w[8]  = act_i[AI_DBG];
        hnd_w[10] = act_i[AI_PSV];
        hnd_w[11] = act_i[AI_STK];
        hnd_w[12] = pend_i[PI_USG];
        hnd_w[13] = pend_i[PI_MEM];
        hnd_w[14] = pend_i[PI_BUS];
        hnd_w[15] = pend_i[PI_SVC];
        hnd_w[HB_EN_LSB +: N_FEN] = fen_i;
    end

    always_comb begin
        case (sel_i)
            SEL_CTRL:  rdata_o = ctrl_w;
            SEL_VBASE: rdata_o = vbase_i;
            SEL_RSTC:  rdata_o = RSTC_RDVAL;
            SEL_HND:   rdata_o = hnd_w;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sysexc_ctrl_regs.sv
module sysexc_ctrl_regs
    import sysexc_pkg::*;
#(
    parameter int          N_EXT      = 64,
    parameter int          VBASE_LSB  = 7,
    parameter logic [15:0] RST_KEY    = 16'h05FA,
    parameter logic [31:0] RSTC_RDVAL = 32'h0FA0_5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [VEC_W-1:0]  act_vec_i,
    input  logic              act_nested_i,
    input  logic [VEC_W-1:0]  pnd_vec_i,
    input  logic [N_EXT-1:0]  ext_pend_i,
    input  logic [N_ACT-1:0]  act_state_i,
    input  logic [N_PEND-1:0] hw_set_i,
    input  logic [N_PEND-1:0] hw_clr_i,
    output logic [N_PEND-1:0] pend_o,
    output logic [N_FEN-1:0]  fault_en_o,
    output logic [DATA_W-1:0] vbase_o,
    output logic              sys_rst_req_o
);

    reg_sel_t          sel;
    pend_req_t         sw_req;
    logic [N_PEND-1:0] set_all;
    logic [N_PEND-1:0] clr_all;
    vec_view_t         view;

    assign sel = decode_ofs(bus_addr);

    always_comb begin
        sw_req = '0;
        if (bus_wr && sel == SEL_CTRL)
            sw_req = ctrl_write_req(bus_wdata);
    end

    assign set_all = sw_req.set | hw_set_i;
    assign clr_all = sw_req.clr | hw_clr_i;

    always_comb begin
        view.act     = act_vec_i;
        view.pnd     = pnd_vec_i;
        view.nested  = act_nested_i;
        view.ext_any = |ext_pend_i;
    end

    sysexc_pend #(.N(N_PEND)) i_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_all),
        .clr_i (clr_all),
        .q_o   (pend_o)
    );

    sysexc_cfg #(.VBASE_LSB(VBASE_LSB), .RST_KEY(RST_KEY)) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_vbase_i (bus_wr && sel == SEL_VBASE),
        .wr_hnd_i   (bus_wr && sel == SEL_HND),
        .wr_rstc_i  (bus_wr && sel == SEL_RSTC),
        .wdata_i    (bus_wdata),
        .vbase_o    (vbase_o),
        .fen_o      (fault_en_o),
        .rst_req_o  (sys_rst_req_o)
    );

    sysexc_rdmux #(.RSTC_RDVAL(RSTC_RDVAL)) i_rdmux (
        .sel_i   (sel),
        .view_i  (view),
        .pend_i  (pend_o),
        .act_i   (act_state_i),
        .fen_i   (fault_en_o),
        .vbase_i (vbase_o),
        .rdata_o (bus_rdata)
    );

endmodule

// File: rtl/sysexc_ctrl_chk.sv
module sysexc_ctrl_chk
    import sysexc_pkg::*;
#(
    parameter int          VBASE_LSB = 7,
    parameter logic [15:0] RST_KEY   = 16'h05FA
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N_PEND-1:0] hw_set_i,
    input logic [N_PEND-1:0] hw_clr_i,
    input logic [N_PEND-1:0] pend_o,
    input logic [N_FEN-1:0]  fault_en_o,
    input logic [DATA_W-1:0] vbase_o,
    input logic              sys_rst_req_o
);

    logic wr_ctrl, wr_vb, wr_hnd, wr_rstc, key_ok;

    assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
    assign wr_vb   = bus_wr && bus_addr == OFS_VBASE;
    assign wr_hnd  = bus_wr && bus_addr == OFS_HND;
    assign wr_rstc = bus_wr && bus_addr == OFS_RSTC;
    assign key_ok  = bus_wdata[31:16] == RST_KEY;

    p_nmi_set_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[31]) |=> pend_o[PI_NMI]);

    p_psv_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[28]) |=> pend_o[PI_PSV]);

    p_psv_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[28] && bus_wdata[27] && !hw_set_i[PI_PSV]) |=> !pend_o[PI_PSV]);

    p_stk_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[26]) |=> pend_o[PI_STK]);

    p_stk_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[26] && bus_wdata[25] && !hw_set_i[PI_STK]) |=> !pend_o[PI_STK]);

    p_fen_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_hnd |=> fault_en_o == $past(bus_wdata[18:16]));

    p_vbase_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr_vb |=> vbase_o[31:VBASE_LSB] == $past(bus_wdata[31:VBASE_LSB]));

    p_rst_cause_r10: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |-> $past(wr_rstc && key_ok && (bus_wdata[0] || bus_wdata[2])));

    p_bad_key_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_rstc && !key_ok) |=> !sys_rst_req_o);

    p_hw_set_r12: assert property (@(posedge clk) disable iff (rst)
        (|hw_set_i) |=> ((pend_o & $past(hw_set_i)) == $past(hw_set_i)));

    p_hw_clr_r12: assert property (@(posedge clk) disable iff (rst)
        (hw_clr_i[PI_MEM] && !hw_set_i[PI_MEM]) |=> !pend_o[PI_MEM]);

endmodule

bind sysexc_ctrl_regs sysexc_ctrl_chk #(
    .VBASE_LSB (VBASE_LSB),
    .RST_KEY   (RST_KEY)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .hw_set_i      (hw_set_i),
    .hw_clr_i      (hw_clr_i),
    .pend_o        (pend_o),
    .fault_en_o    (fault_en_o),
    .vbase_o       (vbase_o),
    .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/test_sysexc_ctrl_regs.sv
module test_sysexc_ctrl_regs;

    localparam int N_EXT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  act_vec_i = 10'd1023;
    logic        act_nested_i = 1'b0;
    logic [9:0]  pnd_vec_i = 10'd1023;
    logic [N_EXT-1:0] ext_pend_i = '0;
    logic [6:0]  act_state_i = '0;
    logic [6:0]  hw_set_i = '0;
    logic [6:0]  hw_clr_i = '0;
    logic [6:0]  pend_o;
    logic [2:0]  fault_en_o;
    logic [31:0] vbase_o;
    logic        sys_rst_req_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sysexc_ctrl_regs #(.N_EXT(N_EXT)) i_sysexc_ctrl_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .act_vec_i     (act_vec_i),
        .act_nested_i  (act_nested_i),
        .pnd_vec_i     (pnd_vec_i),
        .ext_pend_i    (ext_pend_i),
        .act_state_i   (act_state_i),
        .hw_set_i      (hw_set_i),
        .hw_clr_i      (hw_clr_i),
        .pend_o        (pend_o),
        .fault_en_o    (fault_en_o),
        .vbase_o       (vbase_o),
        .sys_rst_req_o (sys_rst_req_o)
    );

    // {offset, write data, expected pend_o after the write}
    localparam logic [50:0] TBL [10] = '{
        {12'hD04, 32'h8000_0000, 7'b0000001},
        {12'hD04, 32'h1000_0000, 7'b0000011},
        {12'hD04, 32'h0800_0000, 7'b0000001},
        {12'hD04, 32'h1800_0000, 7'b0000011},
        {12'hD04, 32'h0400_0000, 7'b0000111},
        {12'hD04, 32'h0200_0000, 7'b0000011},
        {12'hD04, 32'h0600_0000, 7'b0000111},
        {12'hD04, 32'h0A00_0000, 7'b0000001},
        {12'hD08, 32'h0000_0012, 7'b0000001},
        {12'hD0C, 32'h05FB_0005, 7'b0000001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_hw(input logic [11:0] a, input logic [31:0] d,
                         input logic we, input logic [6:0] s, input logic [6:0] c);
        @(negedge clk);
        bus_wr    = we;
        bus_addr  = a;
        bus_wdata = d;
        hw_set_i  = s;
        hw_clr_i  = c;
        @(negedge clk);
        bus_wr   = 1'b0;
        hw_set_i = '0;
        hw_clr_i = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_hw(a, d, 1'b1, 7'b0, 7'b0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13: reset state
        chk("R13 pend", {25'b0, pend_o}, 32'h0);
        chk("R13 fen", {29'b0, fault_en_o}, 32'h0);
        chk("R13 vbase", vbase_o, 32'h0);
        chk("R13 req", {31'b0, sys_rst_req_o}, 32'h0);
        rd(12'hD0C, r); chk("R9 readback", r, 32'h0FA0_5000);
        rd(12'h000, r); chk("R14 unmapped read", r, 32'h0);

        // R1/R2/R3/R11: table walk
        for (int i = 0; i < 10; i++) begin
            wr(TBL[i][50:39], TBL[i][38:7]);
            chk($sformatf("R1/R2/R3/R11 row %0d", i), {25'b0, pend_o}, {25'b0, TBL[i][6:0]});
        end
        chk("R11 no req after bad key", {31'b0, sys_rst_req_o}, 32'h0);

        // R12: strobes combined with register writes
        wr_hw(12'hD04, 32'h0800_0000, 1'b1, 7'b0000010, 7'b0);
        chk("R12 hw set beats sw clear", {25'b0, pend_o}, 32'h03);
        wr_hw(12'hD04, 32'h8000_0000, 1'b1, 7'b0010000, 7'b0);
        chk("R12 hw set ORed with sw set", {25'b0, pend_o}, 32'h13);
        wr_hw(12'h000, 32'h0, 1'b0, 7'b0, 7'b0010001);
        chk("R12 hw clear", {25'b0, pend_o}, 32'h02);
        wr_hw(12'h000, 32'h0, 1'b0, 7'b0000100, 7'b0000100);
        chk("R12 hw set beats hw clear", {25'b0, pend_o}, 32'h06);

        // R4/R5: control/state read layout, pend = deferred call + tick
        act_vec_i = 10'd35; act_nested_i = 1'b1; pnd_vec_i = 10'd40; ext_pend_i = 64'h20;
        rd(12'hD04, r); chk("R4 R5 translated fields", r, 32'h1441_8013);
        act_vec_i = 10'd1023; act_nested_i = 1'b0; pnd_vec_i = 10'd1023; ext_pend_i = '0;
        rd(12'hD04, r); chk("R4 R5 nothing active", r, 32'h1400_0800);
        act_vec_i = 10'd14; act_nested_i = 1'b1; pnd_vec_i = 10'd15;
        rd(12'hD04, r); chk("R5 low vectors unchanged", r, 32'h1400_F00E);
        act_vec_i = 10'd47; act_nested_i = 1'b0; pnd_vec_i = 10'd1023;
        ext_pend_i = 64'h8000_0000_0000_0000;
        rd(12'hD04, r); chk("R4 single level and top external", r, 32'h1440_081F);
        ext_pend_i = '0;

        // R6/R7: handler status
        wr_hw(12'h000, 32'h0, 1'b0, 7'b1111000, 7'b0);
        wr(12'hD24, 32'h0007_0000);
        chk("R7 enables loaded", {29'b0, fault_en_o}, 32'h7);
        act_state_i = 7'h7F;
        rd(12'hD24, r); chk("R6 all set", r, 32'h0007_FD8B);
        wr_hw(12'h000, 32'h0, 1'b0, 7'b0, 7'b0111000);
        wr(12'hD24, 32'h0002_0000);
        chk("R7 bus enable only", {29'b0, fault_en_o}, 32'h2);
        act_state_i = 7'b1000001;
        rd(12'hD24, r); chk("R6 mixed", r, 32'h0002_8801);
        act_state_i = '0;

        // R8: vector base
        wr(12'hD08, 32'hFFFF_FFFF);
        rd(12'hD08, r); chk("R8 read masks low bits", r, 32'hFFFF_FF80);
        chk("R8 output", vbase_o, 32'hFFFF_FF80);
        wr(12'hD08, 32'h2000_00FF);
        chk("R8 second value", vbase_o, 32'h2000_0080);

        // R14: write to unmapped offset changes nothing
        wr(12'hD10, 32'hFFFF_FFFF);
        chk("R14 pend kept", {25'b0, pend_o}, 32'h46);
        chk("R14 fen kept", {29'b0, fault_en_o}, 32'h2);
        chk("R14 vbase kept", vbase_o, 32'h2000_0080);
        rd(12'hD10, r); chk("R14 read zero", r, 32'h0);

        // R10/R11: keyed reset request
        wr(12'hD0C, 32'h05FA_0004);
        chk("R10 pulse on bit2", {31'b0, sys_rst_req_o}, 32'h1);
        @(negedge clk);
        chk("R10 pulse one cycle", {31'b0, sys_rst_req_o}, 32'h0);
        wr(12'hD0C, 32'h05FA_0001);
        chk("R10 pulse on bit0", {31'b0, sys_rst_req_o}, 32'h1);
        wr(12'hD0C, 32'h05FA_0002);
        chk("R11 other bit no pulse", {31'b0, sys_rst_req_o}, 32'h0);
        wr(12'hD0C, 32'h05FB_0005);
        chk("R11 wrong key no pulse", {31'b0, sys_rst_req_o}, 32'h0);
        chk("R11 state kept", vbase_o, 32'h2000_0080);

        done = 1'b1;
        summary();
    end

endmodule